// File: doc/BRIEF.md
# Transmit ATM Cell Generator

This block produces the outgoing stream of 53-byte ATM cells that a SONET/SDH payload mapper consumes one byte at a time. A cell source on the transmit side writes bytes into an internal elastic store that holds a parameterised number of whole cells (four by default). The downstream mapper raises a byte-enable whenever it has room for a payload byte. At every cell boundary the generator decides what to send next. A complete stored cell goes first. If none is stored, a software-described filler cell (idle or unassigned) is sent. If filler insertion is off, nothing is sent.

For every cell the generator can replace the fifth byte with a freshly computed header check byte, and a test mask can corrupt that byte. The 48 payload bytes pass through a self-synchronous x^43+1 scrambler. Filler payload follows one of three selectable patterns. Three saturating counters track filler cells, stored cells sent, and stored cells sent with a corrupted check byte. A single strobe clears all three counters.

Top module: `atm_tx_cell_gen`

## Requirements
- R1: After reset, out_valid, out_sop and out_byte are 0, all three counters are 0 and wr_ready is 1.
- R2: A byte is produced only on a clock edge where out_en is 1. After an edge with out_en at 0, out_valid is 0 and out_byte keeps its previous value.
- R3: At a cell boundary, a complete stored cell takes precedence. Its bytes leave in write order, with bytes 0 to 3 unchanged. out_sop marks byte 0.
- R4: The store accepts bytes while it holds fewer than CELLS×53 bytes. wr_ready is 0 when the store is full, and a byte offered while it is full is discarded.
- R5: When no complete cell is stored and cfg_fill_en is 1, a filler cell is sent with header bytes cfg_fill_hdr[39:32], [31:24], [23:16], [15:8]. When cfg_fill_en is 0, an enabled boundary edge gives out_valid 0 and no cell starts.
- R6: With cfg_fill_mode 0 (or 3), every filler payload byte before scrambling equals cfg_fill_byte.
- R7: With cfg_fill_mode 1, every payload byte of a filler cell equals a sequence value. The value is 0 after reset and goes up by one (mod 256) after each filler cell, whatever its mode.
- R8: With cfg_fill_mode 2, payload byte k (k = 0..47) before scrambling equals cfg_fill_byte + k, mod 256.
- R9: With cfg_hec_en 1, byte 4 equals CRC-8 (x^8+x^2+x+1, initial value 0, MSB first over bytes 0..3) XOR 0x55 XOR cfg_hec_mask. With cfg_hec_en 0, byte 4 is the stored byte for a data cell, or cfg_fill_hdr[7:0] for a filler cell.
- R10: Bytes 5..52 are scrambled MSB first: out = in XOR (the output bit 43 positions earlier). The scrambler state is zero after reset, advances only on payload bytes, and carries over from one cell to the next.
- R11: fill_cnt counts filler cells, data_cnt counts stored cells, and corr_cnt counts stored cells started with cfg_hec_en 1 and a nonzero cfg_hec_mask. Each counter steps on the edge of the cell's first byte.
- R12: Each counter stops at its all-ones value.
- R13: cnt_clr zeroes all three counters. A cell starting on the same edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Cell source offers a byte |
| wr_byte | input | 8 | Offered byte |
| wr_ready | output | 1 | Store has room for a byte |
| out_en | input | 1 | Mapper takes a byte on this edge |
| out_byte | output | 8 | Produced byte |
| out_valid | output | 1 | out_byte was produced on the last edge |
| out_sop | output | 1 | out_byte is byte 0 of a cell |
| cfg_fill_en | input | 1 | Filler insertion enable |
| cfg_fill_mode | input | 2 | Filler payload pattern select |
| cfg_fill_byte | input | 8 | Filler constant or ramp start |
| cfg_fill_hdr | input | 40 | Filler header bytes 0..4, byte 0 in the top bits |
| cfg_hec_en | input | 1 | Compute the check byte |
| cfg_hec_mask | input | 8 | XOR mask applied to the computed check byte |
| cnt_clr | input | 1 | Clear strobe for all counters |
| fill_cnt | output | CNT_W | Filler cells sent |
| data_cnt | output | CNT_W | Stored cells sent |
| corr_cnt | output | CORR_W | Stored cells sent with a masked check byte |

## Verification
The bench builds the block with CELLS=4, CNT_W=6 and CORR_W=4. The narrow counters let a few thousand cycles of filler and masked data cells drive both counter kinds into saturation. A four-cell store is small enough to fill completely, so a byte offered while the store is full can be shown to vanish: the next cell written afterwards must come out intact. The filler sequence value and the scrambler state run across every cell of the run, so any slip shows up in later cells.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HEC_IDX    = 4;
  localparam int PAY_IDX    = 5;
  localparam int SCR_TAPS   = 43;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DATA = 2'd1,
    SRC_FILL = 2'd2
  } cell_src_e;

  typedef struct packed {
    logic [SCR_TAPS-1:0] st;
    logic [7:0]          q;
  } scr_out_t;

  // one byte of CRC-8, generator x^8+x^2+x+1, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    return c;
  endfunction

  // self-synchronous x^43+1 scrambling of one byte, MSB first
  function automatic scr_out_t scramble_byte(input logic [SCR_TAPS-1:0] st, input logic [7:0] d);
    scr_out_t r;
    logic [SCR_TAPS-1:0] s;
    logic [7:0] q;
    s = st;
    for (int b = 7; b >= 0; b--) begin
      q[b] = d[b] ^ s[SCR_TAPS-1];
      s    = {s[SCR_TAPS-2:0], q[b]};
    end
    r.st = s;
    r.q  = q;
    return r;
  endfunction

  // unscrambled filler payload byte number idx (0..47)
  function automatic logic [7:0] fill_payload(input logic [1:0] mode, input logic [7:0] base,
                                              input logic [7:0] seq, input logic [7:0] idx);
    case (mode)
      2'd1:    return seq;
      2'd2:    return base + idx;
      default: return base;
    endcase
  endfunction
endpackage

// File: rtl/atm_cell_store.sv
module atm_cell_store #(
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_byte,
  output logic       wr_ready,
  input  logic       rd_en,
  output logic [7:0] rd_byte,
  input  logic       cell_take,
  output logic       cell_avail
);
  localparam int BYTES = CELLS * CELL_BYTES;
  localparam int AW    = $clog2(BYTES);
  localparam int OW    = $clog2(BYTES + 1);
  localparam int CW    = $clog2(CELLS + 1);
  localparam int BW    = $clog2(CELL_BYTES);
  localparam logic [AW-1:0] LAST_ADDR = AW'(BYTES - 1);
  localparam logic [BW-1:0] LAST_IDX  = BW'(CELL_BYTES - 1);

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] occ;
  logic [CW-1:0] cell_cnt;
  logic [BW-1:0] wr_idx;
  logic          wr_fire, cell_done;

  assign wr_ready   = occ < OW'(BYTES);
  assign wr_fire    = wr_valid && wr_ready;
  assign cell_done  = wr_fire && (wr_idx == LAST_IDX);
  assign cell_avail = cell_cnt != '0;
  assign rd_byte    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ      <= '0;
      cell_cnt <= '0;
      wr_idx   <= '0;
    end else begin
      if (wr_fire) begin
        wr_ptr <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + 1'b1;
        wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      end
      if (rd_en) rd_ptr <= (rd_ptr == LAST_ADDR) ? '0 : rd_ptr + 1'b1;
      case ({wr_fire, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      case ({cell_done, cell_take})
        2'b10:   cell_cnt <= cell_cnt + 1'b1;
        2'b01:   cell_cnt <= cell_cnt - 1'b1;
        default: cell_cnt <= cell_cnt;
      endcase
    end
  end

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> occ != '0); // R3
  AST_TAKE_WHOLE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    cell_take |-> occ >= OW'(CELL_BYTES)); // R3
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_TAPS-1:0] st_q;
  scr_out_t            res;

  assign res  = scramble_byte(st_q, din);
  assign dout = res.q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= '0;
    else if (step) st_q <= res.st;
  end

  AST_SCR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(st_q)); // R10
endmodule

// File: rtl/atm_sat_counter.sv
module atm_sat_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !clr) |=> cnt == '1); // R12
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R13
endmodule

// File: rtl/atm_tx_cell_gen.sv
module atm_tx_cell_gen
  import atm_tx_pkg::*;
#(
  parameter int CELLS  = 4,
  parameter int CNT_W  = 24,
  parameter int CORR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_byte,
  output logic              wr_ready,
  input  logic              out_en,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              out_sop,
  input  logic              cfg_fill_en,
  input  logic [1:0]        cfg_fill_mode,
  input  logic [7:0]        cfg_fill_byte,
  input  logic [39:0]       cfg_fill_hdr,
  input  logic              cfg_hec_en,
  input  logic [7:0]        cfg_hec_mask,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic [CNT_W-1:0]  data_cnt,
  output logic [CORR_W-1:0] corr_cnt
);
  localparam int PW = $clog2(CELL_BYTES);
  localparam logic [PW-1:0] LAST_POS = PW'(CELL_BYTES - 1);
  localparam logic [PW-1:0] HEC_POS  = PW'(HEC_IDX);
  localparam logic [PW-1:0] PAY_POS  = PW'(PAY_IDX);

  logic [PW-1:0] pos_q;
  cell_src_e     cur_q, kind;
  logic [7:0]    crc_q, crc_nxt, seq_q;
  logic [7:0]    rd_byte, hdr_sel, raw, scr_q, hec_byte, out_nxt;
  logic          cell_avail, at_bound, active, in_payload;
  // named events for assertions and counters
  logic          cell_take, fill_start, fill_end, corr_start;

  assign at_bound   = pos_q == '0;
  assign kind       = at_bound ? (cell_avail ? SRC_DATA : (cfg_fill_en ? SRC_FILL : SRC_NONE)) : cur_q;
  assign active     = out_en && (kind != SRC_NONE);
  assign in_payload = pos_q >= PAY_POS;
  assign cell_take  = active && at_bound && (kind == SRC_DATA);
  assign fill_start = active && at_bound && (kind == SRC_FILL);
  assign fill_end   = active && (pos_q == LAST_POS) && (kind == SRC_FILL);
  assign corr_start = cell_take && cfg_hec_en && (cfg_hec_mask != 8'h00);

  atm_cell_store #(.CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_ready(wr_ready),
    .rd_en(active && kind == SRC_DATA), .rd_byte(rd_byte),
    .cell_take(cell_take), .cell_avail(cell_avail)
  );

  always_comb begin
    case (pos_q)
      PW'(0):  hdr_sel = cfg_fill_hdr[39:32];
      PW'(1):  hdr_sel = cfg_fill_hdr[31:24];
      PW'(2):  hdr_sel = cfg_fill_hdr[23:16];
      PW'(3):  hdr_sel = cfg_fill_hdr[15:8];
      default: hdr_sel = cfg_fill_hdr[7:0];
    endcase
  end

  always_comb begin
    if (kind == SRC_DATA)   raw = rd_byte;
    else if (!in_payload)   raw = hdr_sel;
    else                    raw = fill_payload(cfg_fill_mode, cfg_fill_byte, seq_q,
                                               8'(pos_q) - 8'(PAY_IDX));
  end

  assign crc_nxt  = crc8_step(at_bound ? 8'h00 : crc_q, raw);
  assign hec_byte = crc_q ^ HEC_COSET ^ cfg_hec_mask;

  always_comb begin
    if (in_payload)                          out_nxt = scr_q;
    else if (pos_q == HEC_POS && cfg_hec_en) out_nxt = hec_byte;
    else                                     out_nxt = raw;
  end

  atm_payload_scrambler u_scr (
    .clk(clk), .rst_n(rst_n),
    .step(active && in_payload), .din(raw), .dout(scr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      cur_q     <= SRC_NONE;
      crc_q     <= '0;
      seq_q     <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
    end else begin
      out_valid <= active;
      out_sop   <= active && at_bound;
      if (active) begin
        out_byte <= out_nxt;
        pos_q    <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        if (pos_q < HEC_POS) crc_q <= crc_nxt;
        if (at_bound) cur_q <= kind;
      end
      if (fill_end) seq_q <= seq_q + 8'd1;
    end
  end

  atm_sat_counter #(.W(CNT_W)) u_fill_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(fill_start), .cnt(fill_cnt));
  atm_sat_counter #(.W(CNT_W)) u_data_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cell_take), .cnt(data_cnt));
  atm_sat_counter #(.W(CORR_W)) u_corr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(corr_start), .cnt(corr_cnt));

  AST_STALL_HOLDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (!out_valid && $stable(out_byte))); // R2
  AST_SOP_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_valid && pos_q == PW'(1))); // R3
  AST_NO_FILL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && at_bound && !cfg_fill_en && !cell_avail) |=> !out_valid); // R5
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> !cell_avail); // R3
endmodule

// File: tb/atm_tx_cell_gen_test.sv
module atm_tx_cell_gen_test;
  localparam int CNT_W  = 6;
  localparam int CORR_W = 4;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int CORR_MAX = (1 << CORR_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, out_en = 1'b0, cfg_fill_en = 1'b0, cfg_hec_en = 1'b1, cnt_clr = 1'b0;
  logic [7:0] wr_byte = '0, cfg_fill_byte = '0, cfg_hec_mask = '0;
  logic [1:0] cfg_fill_mode = '0;
  logic [39:0] cfg_fill_hdr = '0;
  logic wr_ready, out_valid, out_sop;
  logic [7:0] out_byte;
  logic [CNT_W-1:0] fill_cnt, data_cnt;
  logic [CORR_W-1:0] corr_cnt;

  always #5 clk = ~clk;

  atm_tx_cell_gen #(.CELLS(4), .CNT_W(CNT_W), .CORR_W(CORR_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_ready(wr_ready),
    .out_en(out_en), .out_byte(out_byte), .out_valid(out_valid), .out_sop(out_sop),
    .cfg_fill_en(cfg_fill_en), .cfg_fill_mode(cfg_fill_mode), .cfg_fill_byte(cfg_fill_byte),
    .cfg_fill_hdr(cfg_fill_hdr), .cfg_hec_en(cfg_hec_en), .cfg_hec_mask(cfg_hec_mask),
    .cnt_clr(cnt_clr), .fill_cnt(fill_cnt), .data_cnt(data_cnt), .corr_cnt(corr_cnt)
  );

  int n_chk = 0, n_fail = 0;
  int e_fill = 0, e_data = 0, e_corr = 0;
  int fill_seq = 0;
  logic [42:0] hist = '0;       // hist[42] = output bit 43 places back
  logic [7:0] exp_raw [53];
  logic [7:0] cell_img [53];

  // stimulus vectors: [58] hec_en, [57:50] mask, [49:48] mode, [47:40] base, [39:0] header
  localparam logic [58:0] VECS [6] = '{
    {1'b1, 8'h00, 2'd0, 8'h00, 40'h00000001_52},
    {1'b0, 8'h00, 2'd0, 8'hA5, 40'h00000000_3C},
    {1'b1, 8'h01, 2'd1, 8'h00, 40'h00000003_00},
    {1'b1, 8'h00, 2'd1, 8'h77, 40'h12345678_00},
    {1'b1, 8'h00, 2'd2, 8'hF0, 40'h0000000F_00},
    {1'b0, 8'h00, 2'd2, 8'h10, 40'hA0B0C0D0_E1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int mx);
    return (v > mx) ? mx : v;
  endfunction

  // bit-serial reference of the check byte over a 32-bit header
  function automatic logic [7:0] hec_ref(input logic [31:0] h, input logic [7:0] mask);
    logic [7:0] c = 8'h00;
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ h[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'b0000_0111;
    end
    return c ^ 8'h55 ^ mask;
  endfunction

  task automatic scr_ref(input logic [7:0] d, output logic [7:0] q);
    for (int b = 7; b >= 0; b--) begin
      q[b] = d[b] ^ hist[42];
      hist = {hist[41:0], q[b]};
    end
  endtask

  task automatic tick(input logic en, input logic clr);
    @(negedge clk);
    out_en = en; cnt_clr = clr; wr_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic wbyte(input logic [7:0] b);
    @(negedge clk);
    out_en = 1'b0; wr_valid = 1'b1; wr_byte = b;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic run_cell(input string req, input logic clr_first);
    logic [7:0] e;
    for (int i = 0; i < 53; i++) begin
      tick(1'b1, clr_first && i == 0);
      if (i >= 5) scr_ref(exp_raw[i], e); else e = exp_raw[i];
      chk(req, out_byte, e);
      if (i == 0) chk({req, " sop"}, {out_valid, out_sop}, 2'b11);
    end
    cnt_clr = 1'b0;
  endtask

  task automatic build_fill(input logic [58:0] v);
    cfg_hec_en = v[58]; cfg_hec_mask = v[57:50]; cfg_fill_mode = v[49:48];
    cfg_fill_byte = v[47:40]; cfg_fill_hdr = v[39:0];
    for (int i = 0; i < 4; i++) exp_raw[i] = v[39 - 8*i -: 8];
    exp_raw[4] = v[58] ? hec_ref(v[39:8], v[57:50]) : v[7:0];
    for (int i = 5; i < 53; i++)
      case (v[49:48])
        2'd1:    exp_raw[i] = 8'(fill_seq);
        2'd2:    exp_raw[i] = v[47:40] + 8'(i - 5);
        default: exp_raw[i] = v[47:40];
      endcase
  endtask

  task automatic fill_cell(input string req, input logic [58:0] v, input logic clr_first);
    build_fill(v);
    run_cell(req, clr_first);
    fill_seq++;
    e_fill = clr_first ? 0 : e_fill + 1;
    if (clr_first) begin e_data = 0; e_corr = 0; end
  endtask

  task automatic make_img(input int seed);
    for (int i = 0; i < 53; i++) cell_img[i] = 8'(seed * 13 + i * 7);
  endtask

  task automatic write_img();
    for (int i = 0; i < 53; i++) wbyte(cell_img[i]);
  endtask

  task automatic data_cell(input string req);
    for (int i = 0; i < 53; i++) exp_raw[i] = cell_img[i];
    if (cfg_hec_en) exp_raw[4] = hec_ref({cell_img[0], cell_img[1], cell_img[2], cell_img[3]}, cfg_hec_mask);
    run_cell(req, 1'b0);
    e_data++;
    if (cfg_hec_en && cfg_hec_mask != 0) e_corr++;
  endtask

  task automatic chk_counts(input string req);
    chk({req, " fill_cnt"}, fill_cnt, sat(e_fill, CNT_MAX));
    chk({req, " data_cnt"}, data_cnt, sat(e_data, CNT_MAX));
    chk({req, " corr_cnt"}, corr_cnt, sat(e_corr, CORR_MAX));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 outputs", {out_valid, out_sop, out_byte}, 10'h0);
    chk("R1 counters", {fill_cnt, data_cnt, corr_cnt}, '0);
    chk("R1 wr_ready", wr_ready, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R5 no filler when disabled, empty store
    tick(1'b1, 1'b0);
    chk("R5 idle when fill off", out_valid, 1'b0);

    // R6 R7 R8 R9 R10 table walk of filler cells
    cfg_fill_en = 1'b1;
    for (int k = 0; k < 6; k++) fill_cell("R6/R7/R8 R9 R10 filler vector", VECS[k], 1'b0);
    chk_counts("R11 after filler table");

    // R2 stall holds byte
    held = out_byte;
    tick(1'b0, 1'b0);
    chk("R2 stall valid", out_valid, 1'b0);
    chk("R2 stall byte", out_byte, held);

    // R3 R9 data cells: computed, passthrough, masked
    cfg_hec_en = 1'b1; cfg_hec_mask = 8'h00;
    make_img(1); write_img(); data_cell("R3 R9 data cell computed check");
    cfg_hec_en = 1'b0;
    make_img(2); write_img(); data_cell("R9 data cell passthrough");
    cfg_hec_en = 1'b1; cfg_hec_mask = 8'h80;
    make_img(3); write_img(); data_cell("R9 data cell masked");
    chk_counts("R11 after data cells");

    // R4 full store, extra byte discarded
    cfg_hec_mask = 8'h00; cfg_fill_en = 1'b0;
    for (int c = 0; c < 4; c++) begin
      make_img(10 + c);
      for (int i = 0; i < 53; i++) begin
        if (c == 3 && i == 52) chk("R4 ready before full", wr_ready, 1'b1);
        wbyte(cell_img[i]);
      end
    end
    chk("R4 ready when full", wr_ready, 1'b0);
    wbyte(8'hEE);
    for (int c = 0; c < 4; c++) begin
      make_img(10 + c);
      data_cell("R4 R3 stored cell order");
    end
    tick(1'b1, 1'b0);
    chk("R4 R5 store drained", out_valid, 1'b0);
    make_img(20); write_img(); data_cell("R4 extra byte discarded");

    // R13 clear strobe
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    e_fill = 0; e_data = 0; e_corr = 0;
    chk_counts("R13 clear");
    cfg_fill_en = 1'b1;
    fill_cell("R13 clear wins filler", VECS[0], 1'b1);
    chk("R13 clear wins over start", fill_cnt, 0);
    fill_cell("R7 filler after clear", VECS[2], 1'b0);
    chk("R11 count after clear", fill_cnt, 1);

    // R12 saturation
    for (int k = 0; k < 66; k++) fill_cell("R12 filler run", VECS[k % 6], 1'b0);
    chk("R12 fill_cnt saturates", fill_cnt, CNT_MAX);
    cfg_hec_en = 1'b1; cfg_hec_mask = 8'h3C;
    for (int k = 0; k < 17; k++) begin
      make_img(30 + k); write_img(); data_cell("R12 masked data run");
    end
    chk_counts("R12 R11 saturation");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule